// File: doc/BRIEF.md
# SD Card Command Line Sequencer

This block drives one command at a time onto the single-wire command line of an SD or MMC card, then, when the command calls for it, listens for the card's answer and checks it. A command consists of a 6-bit index, a 32-bit argument, a 2-bit answer kind and an optional abort qualifier. It is accepted on a one-cycle start pulse. All line activity moves forward only on cycles where the card-clock strobe `tick` is high. The outgoing word is 48 bits long and carries its own CRC7. The answer is either 48 or 136 bits long. Its payload is placed in four 32-bit words, and its outcome is recorded in four sticky flags that software clears by writing ones.

The controller has four states. ST_IDLE moves to ST_SEND on a start pulse. ST_SEND moves to ST_IDLE after the 48th bit when no answer is wanted, and to ST_WAIT otherwise. ST_WAIT moves to ST_RECV when a 0 start bit is seen, and back to ST_IDLE when the wait limit runs out. ST_RECV moves to ST_IDLE after the last answer bit. Outside ST_SEND the line is released and reads 1.

Top module: `sdcmd_path`

## Requirements
- R1: While `cmd_oe` is high, the 48-bit frame goes out MSB first, one bit per tick, for exactly 48 ticks. From first to last the frame is: 0, 1, the index, the argument, CRC7 (polynomial x^7+x^3+1, taken over the first 40 frame bits), 1.
- R2: A start pulse (`cmd_en`=1) starts a command only in ST_IDLE. A start pulse while busy has no effect on the frame being sent, the answer handling or the flags.
- R3: With `resp_type`=00, no answer is awaited. Flag bit 3 (sent) is set on the tick that ends the last frame bit, and `busy` falls in the same cycle.
- R4: With `resp_type`=01 or 10, a 48-bit answer is received. `resp_w0` takes answer bits 39:8 and `resp_w1`..`resp_w3` read 0. Flag bit 2 (answer received) is set when the answer is accepted.
- R5: With `resp_type`=01, answer bits 7:1 must equal CRC7 over answer bits 47:8. On a mismatch, flag bit 0 (CRC fail) is set instead of bit 2. With `resp_type`=10, bit 0 is never set.
- R6: With `resp_type`=11, a 136-bit answer is received. `resp_w0`..`resp_w3` hold answer bits 127:96, 95:64, 63:32 and 31:0. The CRC7 remainder over bits 127 down to 1 must be zero; otherwise flag bit 0 is set instead of bit 2.
- R7: If no 0 start bit is sampled within 64 ticks after the end bit, flag bit 1 (timeout) is set, bit 2 stays clear, and the block returns to idle. A start bit on the 64th tick is still accepted.
- R8: The flags are sticky. A 1 in `flag_clr` at the same bit position clears that flag, and a set in the same cycle wins over a clear.
- R9: `abort_active` is high while a command started with `stop_cmd`=1 is in progress, and low otherwise.
- R10: After reset, and whenever the block is not sending, `cmd_oe` is 0 and `cmd_out` is 1. At reset the flags are 0 and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Card-clock strobe; line activity advances only when high |
| cmd_en | input | 1 | Start pulse; accepted only when idle |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| resp_type | input | 2 | 00 none, 01 short checked, 10 short unchecked, 11 long |
| stop_cmd | input | 1 | Marks the command as a transfer abort |
| flag_clr | input | 4 | Write-one-to-clear for the flags |
| cmd_in | input | 1 | Sampled command line from the card |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Drive enable for the external line buffer |
| resp_w0 | output | 32 | Answer word 0 |
| resp_w1 | output | 32 | Answer word 1 |
| resp_w2 | output | 32 | Answer word 2 |
| resp_w3 | output | 32 | Answer word 3 |
| flags | output | 4 | bit0 CRC fail, bit1 timeout, bit2 answer received, bit3 sent |
| busy | output | 1 | High while not in ST_IDLE |
| abort_active | output | 1 | High while an abort command is in progress |

## Verification
On every cycle, the assertions check the following: the sent flag is raised only for commands with no answer; a CRC failure never appears together with the received flag and never for unchecked answers; a timeout is raised only from the waiting state; the drive enable falls only after the 48th bit; the write-one-to-clear rule holds; and a start pulse while busy leaves the latched command unchanged. Only the bench scenarios can show the exact frame bits and CRC values, how answer payload bits map onto the four words, and the 64-tick wait boundary. They also show that a start pulse in the middle of a frame leaves the serialized frame intact.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    typedef enum logic [1:0] {
        RT_NONE      = 2'b00,
        RT_SHORT_CRC = 2'b01,
        RT_SHORT_RAW = 2'b10,
        RT_LONG      = 2'b11
    } rsp_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_RECV
    } cmd_state_e;

    localparam int FLAG_W       = 4;
    localparam int FLG_CRC_FAIL = 0;
    localparam int FLG_TIMEOUT  = 1;
    localparam int FLG_RSP_DONE = 2;
    localparam int FLG_SENT     = 3;
    localparam int CRC_W        = 7;

    // One serial step of CRC7, generator x^7 + x^3 + 1
    function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = b ^ c[CRC_W-1];
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    endfunction

endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7
    import sdcmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= '0;
        end else if (clr) begin
            crc <= '0;
        end else if (en) begin
            crc <= crc7_step(crc, din);
        end
    end

endmodule

// File: rtl/sdcmd_tx_frame.sv
module sdcmd_tx_frame
    import sdcmd_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int ARG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [IDX_W-1:0] idx,
    input  logic [ARG_W-1:0] arg,
    output logic             msb
);

    localparam int BODY_W  = 2 + IDX_W + ARG_W;
    localparam int FRAME_W = BODY_W + CRC_W + 1;

    logic [FRAME_W-1:0] sr_q;
    logic [BODY_W-1:0]  body;
    logic [CRC_W-1:0]   body_crc;

    function automatic logic [CRC_W-1:0] crc_of_body(input logic [BODY_W-1:0] v);
        logic [CRC_W-1:0] c;
        c = '0;
        for (int i = BODY_W - 1; i >= 0; i--) begin
            c = crc7_step(c, v[i]);
        end
        return c;
    endfunction

    assign body     = {1'b0, 1'b1, idx, arg};
    assign body_crc = crc_of_body(body);
    assign msb      = sr_q[FRAME_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '1;
        end else if (load) begin
            sr_q <= {body, body_crc, 1'b1};
        end else if (shift) begin
            sr_q <= {sr_q[FRAME_W-2:0], 1'b1};
        end
    end

endmodule

// File: rtl/sdcmd_path.sv
module sdcmd_path
    import sdcmd_pkg::*;
#(
    parameter int IDX_W         = 6,
    parameter int ARG_W         = 32,
    parameter int WORD_W        = 32,
    parameter int TIMEOUT_TICKS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmd_en,
    input  logic [IDX_W-1:0]  cmd_index,
    input  logic [ARG_W-1:0]  cmd_arg,
    input  logic [1:0]        resp_type,
    input  logic              stop_cmd,
    input  logic [FLAG_W-1:0] flag_clr,
    input  logic              cmd_in,
    output logic              cmd_out,
    output logic              cmd_oe,
    output logic [WORD_W-1:0] resp_w0,
    output logic [WORD_W-1:0] resp_w1,
    output logic [WORD_W-1:0] resp_w2,
    output logic [WORD_W-1:0] resp_w3,
    output logic [FLAG_W-1:0] flags,
    output logic              busy,
    output logic              abort_active
);

    localparam int N_WORDS = 4;
    localparam int FRAME_W = 2 + IDX_W + ARG_W + CRC_W + 1;
    localparam int SHORT_W = FRAME_W;
    localparam int PAY_W   = N_WORDS * WORD_W;
    localparam int LONG_W  = PAY_W + 8;
    localparam int POS_W   = $clog2(LONG_W);
    localparam int TXC_W   = $clog2(FRAME_W);
    localparam int TO_W    = $clog2(TIMEOUT_TICKS);

    cmd_state_e         state_q, state_d;
    rsp_kind_e          rtype_q;
    logic               stop_q;
    logic [TXC_W-1:0]   tx_cnt_q;
    logic [TO_W-1:0]    wait_cnt_q;
    logic [POS_W-1:0]   pos_q;
    logic [PAY_W-1:0]   rx_sr_q, rx_next;
    logic [WORD_W-1:0]  rsp_q [N_WORDS];
    logic [FLAG_W-1:0]  flags_q, set_vec;
    logic [CRC_W-1:0]   crc_rx;
    logic               tx_msb, crc_feed, crc_clr, is_long, crc_checked;

    assign is_long     = (rtype_q == RT_LONG);
    assign crc_checked = (rtype_q != RT_SHORT_RAW);
    assign rx_next     = {rx_sr_q[PAY_W-2:0], cmd_in};

    sdcmd_tx_frame #(.IDX_W(IDX_W), .ARG_W(ARG_W)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (state_q == ST_IDLE && cmd_en),
        .shift (state_q == ST_SEND && tick),
        .idx   (cmd_index),
        .arg   (cmd_arg),
        .msb   (tx_msb)
    );

    // Short answers are checked from their start bit; long ones from bit 127
    assign crc_clr  = (state_q == ST_SEND);
    assign crc_feed = tick && (((state_q == ST_WAIT) && !cmd_in && !is_long) ||
                               ((state_q == ST_RECV) && (pos_q != '0) &&
                                (pos_q <= POS_W'(PAY_W - 1))));

    sdcmd_crc7 u_rx_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (crc_feed),
        .din   (cmd_in),
        .crc   (crc_rx)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and flag events
    always_comb begin
        state_d = state_q;
        set_vec = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_en) state_d = ST_SEND;
            end
            ST_SEND: begin
                if (tick && tx_cnt_q == TXC_W'(FRAME_W - 1)) begin
                    if (rtype_q == RT_NONE) begin
                        state_d            = ST_IDLE;
                        set_vec[FLG_SENT]  = 1'b1;
                    end else begin
                        state_d = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (tick) begin
                    if (!cmd_in) begin
                        state_d = ST_RECV;
                    end else if (wait_cnt_q == TO_W'(TIMEOUT_TICKS - 1)) begin
                        state_d              = ST_IDLE;
                        set_vec[FLG_TIMEOUT] = 1'b1;
                    end
                end
            end
            ST_RECV: begin
                if (tick && pos_q == '0) begin
                    state_d = ST_IDLE;
                    if (crc_checked && crc_rx != '0) set_vec[FLG_CRC_FAIL] = 1'b1;
                    else                             set_vec[FLG_RSP_DONE] = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rtype_q    <= RT_NONE;
            stop_q     <= 1'b0;
            tx_cnt_q   <= '0;
            wait_cnt_q <= '0;
            pos_q      <= '0;
            rx_sr_q    <= '0;
            flags_q    <= '0;
            for (int k = 0; k < N_WORDS; k++) rsp_q[k] <= '0;
        end else begin
            flags_q <= (flags_q & ~flag_clr) | set_vec;
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_en) begin
                        rtype_q  <= rsp_kind_e'(resp_type);
                        stop_q   <= stop_cmd;
                        tx_cnt_q <= '0;
                    end
                end
                ST_SEND: begin
                    if (tick) begin
                        tx_cnt_q   <= tx_cnt_q + 1'b1;
                        wait_cnt_q <= '0;
                    end
                end
                ST_WAIT: begin
                    if (tick) begin
                        wait_cnt_q <= wait_cnt_q + 1'b1;
                        pos_q      <= is_long ? POS_W'(LONG_W - 2) : POS_W'(SHORT_W - 2);
                    end
                end
                ST_RECV: begin
                    if (tick) begin
                        pos_q <= pos_q - 1'b1;
                        if (pos_q <= POS_W'(PAY_W - 1)) rx_sr_q <= rx_next;
                        if (pos_q == '0) begin
                            for (int k = 0; k < N_WORDS; k++) begin
                                if (is_long)     rsp_q[k] <= rx_next[PAY_W-1-k*WORD_W -: WORD_W];
                                else if (k == 0) rsp_q[k] <= rx_next[WORD_W+7:8];
                                else             rsp_q[k] <= '0;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign cmd_oe       = (state_q == ST_SEND);
    assign cmd_out      = (state_q == ST_SEND) ? tx_msb : 1'b1;
    assign busy         = (state_q != ST_IDLE);
    assign abort_active = busy && stop_q;
    assign flags        = flags_q;
    assign resp_w0      = rsp_q[0];
    assign resp_w1      = rsp_q[1];
    assign resp_w2      = rsp_q[2];
    assign resp_w3      = rsp_q[3];

    // R1: drive enable drops only after the last frame bit
    p_oe_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_oe) |-> ($past(tx_cnt_q) == TXC_W'(FRAME_W - 1)));

    // R2: a start pulse while busy does not alter the latched command
    p_ignore_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && cmd_en) |=> (rtype_q == $past(rtype_q) && stop_q == $past(stop_q)));

    // R3: sent flag only for commands without an answer
    p_sent_nores_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[FLG_SENT]) |-> (rtype_q == RT_NONE));

    // R5: CRC failure excludes the received flag and never for unchecked answers
    p_crc_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[FLG_CRC_FAIL]) |-> (rtype_q != RT_SHORT_RAW && !$rose(flags_q[FLG_RSP_DONE])));

    // R7: timeout only arises from the waiting state
    p_timeout_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[FLG_TIMEOUT]) |-> ($past(state_q) == ST_WAIT));

    // R8: a cleared bit with no simultaneous set reads 0 next cycle
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_clr) |=> ((flags_q & $past(flag_clr & ~set_vec)) == '0));

endmodule

// File: tb/sdcmd_path_tb.sv
module sdcmd_path_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        cmd_en = 1'b0;
    logic [5:0]  cmd_index = '0;
    logic [31:0] cmd_arg = '0;
    logic [1:0]  resp_type = '0;
    logic        stop_cmd = 1'b0;
    logic [3:0]  flag_clr = '0;
    logic        cmd_in = 1'b1;
    logic        cmd_out, cmd_oe, busy, abort_active;
    logic [31:0] resp_w0, resp_w1, resp_w2, resp_w3;
    logic [3:0]  flags;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdcmd_path dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_en(cmd_en),
        .cmd_index(cmd_index), .cmd_arg(cmd_arg), .resp_type(resp_type),
        .stop_cmd(stop_cmd), .flag_clr(flag_clr), .cmd_in(cmd_in),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .resp_w0(resp_w0), .resp_w1(resp_w1),
        .resp_w2(resp_w2), .resp_w3(resp_w3), .flags(flags), .busy(busy),
        .abort_active(abort_active)
    );

    typedef struct {
        logic [3:0]   flags;
        logic [1:0]   rt;
        logic [127:0] words;
        string        req;
    } exp_t;

    exp_t         sb_q[$];
    logic [47:0]  frame_q[$];
    logic         card_q[$];
    int           n_checks = 0;
    int           n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference CRC7 by augmented polynomial division with 0x89
    function automatic logic [6:0] crc7_ref(input logic [135:0] v, input int n);
        logic [7:0] r;
        r = '0;
        for (int i = n + 6; i >= 0; i--) begin
            r = {r[6:0], (i >= 7) ? v[i-7] : 1'b0};
            if (r[7]) r = r ^ 8'h89;
        end
        return r[6:0];
    endfunction

    // Card clock strobe, frame capture and card answer model
    int          div = 0;
    logic [47:0] cap = '0;
    int          cap_n = 0;
    always @(negedge clk) begin
        div  = (div + 1) % TICK_DIV;
        tick = (div == 0);
        if (tick && cmd_oe) begin
            cap = {cap[46:0], cmd_out};
            cap_n++;
            if (cap_n == 48) begin
                cap_n = 0;
                if (frame_q.size() == 0) check(1'b0, "R1", "unexpected frame", 128'(cap), '0);
                else begin
                    logic [47:0] f;
                    f = frame_q.pop_front();
                    check(cap == f, "R1", "command frame", 128'(cap), 128'(f));
                end
            end
        end
        if (busy && !cmd_oe) begin
            if (tick) cmd_in = (card_q.size() > 0) ? card_q.pop_front() : 1'b1;
        end else begin
            cmd_in = 1'b1;
        end
    end

    // Scoreboard monitor: compare results when a command completes
    logic prev_busy = 1'b0;
    exp_t mon_e;
    always @(negedge clk) begin
        if (rst_n && prev_busy && !busy) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R3", "unexpected completion", '0, '0);
            end else begin
                mon_e = sb_q.pop_front();
                check(flags == mon_e.flags, mon_e.req, "flags", 128'(flags), 128'(mon_e.flags));
                if (mon_e.rt != 2'b00 && !mon_e.flags[1])
                    check({resp_w0, resp_w1, resp_w2, resp_w3} == mon_e.words, mon_e.req, "answer words",
                          {resp_w0, resp_w1, resp_w2, resp_w3}, mon_e.words);
            end
        end
        prev_busy = busy;
    end

    // Driver: queue expectations and card answer, then launch
    task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] rt,
                         input bit stop, input logic [127:0] pay, input bit respond,
                         input bit corrupt, input int delay, input logic [3:0] xflags,
                         input bit poke, input string req);
        logic [6:0]   c;
        logic [47:0]  srsp;
        logic [135:0] lrsp;
        exp_t         e;
        @(negedge clk); flag_clr = 4'hF;
        @(negedge clk); flag_clr = 4'h0;
        c = crc7_ref(136'({2'b01, idx, arg}), 40);
        frame_q.push_back({2'b01, idx, arg, c, 1'b1});
        e.flags = xflags; e.rt = rt; e.req = req; e.words = '0;
        if (respond && rt != 2'b00) begin
            repeat (delay) card_q.push_back(1'b1);
            if (rt == 2'b11) begin
                c = crc7_ref(136'(pay[127:8]), 120);
                if (corrupt) c = c ^ 7'h01;
                lrsp = {2'b00, 6'h3F, pay[127:8], c, 1'b1};
                for (int i = 135; i >= 0; i--) card_q.push_back(lrsp[i]);
                e.words = {pay[127:8], c, 1'b1};
            end else begin
                c = crc7_ref(136'({2'b00, idx, pay[127:96]}), 40);
                if (corrupt) c = c ^ 7'h01;
                srsp = {2'b00, idx, pay[127:96], c, 1'b1};
                for (int i = 47; i >= 0; i--) card_q.push_back(srsp[i]);
                e.words = {pay[127:96], 96'b0};
            end
        end
        sb_q.push_back(e);
        cmd_index = idx; cmd_arg = arg; resp_type = rt; stop_cmd = stop; cmd_en = 1'b1;
        @(negedge clk); cmd_en = 1'b0;
        if (poke) begin
            repeat (8) @(negedge clk);
            cmd_index = ~idx; cmd_arg = ~arg; resp_type = ~rt; cmd_en = 1'b1;
            @(negedge clk); cmd_en = 1'b0;
        end
        if (stop) begin
            repeat (4) @(negedge clk);
            check(abort_active === 1'b1, "R9", "abort during command", 128'(abort_active), 128'(1));
        end
        while (busy) @(negedge clk);
        @(negedge clk);
        check(abort_active === 1'b0, "R9", "abort after command", 128'(abort_active), 128'(0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    localparam logic [127:0] PAY_A = 128'hDEADBEEF_01234567_89ABCDEF_F00DCAFE;
    localparam logic [127:0] PAY_B = 128'h00000900_FFFFFFFF_00000000_A5A5A5A5;

    initial begin
        repeat (5) @(negedge clk);
        check(cmd_out === 1'b1 && cmd_oe === 1'b0, "R10", "idle line", {cmd_out, cmd_oe}, 2'b10);
        check(flags === 4'h0, "R10", "reset flags", 128'(flags), '0);
        check(busy === 1'b0, "R10", "reset busy", 128'(busy), '0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        issue(6'd0,  32'h0000_0000, 2'b00, 1'b0, '0, 1'b0, 1'b0, 0, 4'b1000, 1'b0, "R3");
        issue(6'h3F, 32'hFFFF_FFFF, 2'b00, 1'b1, '0, 1'b0, 1'b0, 0, 4'b1000, 1'b0, "R9");
        issue(6'd17, 32'h1234_5678, 2'b01, 1'b0, PAY_A, 1'b1, 1'b0, 2, 4'b0100, 1'b0, "R4");
        issue(6'd13, 32'h0000_0001, 2'b01, 1'b0, PAY_B, 1'b1, 1'b1, 3, 4'b0001, 1'b0, "R5");
        issue(6'd41, 32'hCAFE_0000, 2'b10, 1'b0, PAY_A, 1'b1, 1'b1, 1, 4'b0100, 1'b0, "R5");
        issue(6'd2,  32'h0000_0000, 2'b11, 1'b0, PAY_A, 1'b1, 1'b0, 4, 4'b0100, 1'b0, "R6");
        issue(6'd9,  32'hABCD_0000, 2'b11, 1'b0, PAY_B, 1'b1, 1'b1, 0, 4'b0001, 1'b0, "R6");
        issue(6'd55, 32'h0F0F_0F0F, 2'b01, 1'b0, PAY_A, 1'b0, 1'b0, 0, 4'b0010, 1'b0, "R7");
        issue(6'd8,  32'h0000_01AA, 2'b01, 1'b0, PAY_B, 1'b1, 1'b0, 63, 4'b0100, 1'b0, "R7");
        issue(6'd12, 32'h5555_AAAA, 2'b00, 1'b0, '0, 1'b0, 1'b0, 0, 4'b1000, 1'b1, "R2");

        // R8: clear touches only the written position
        flag_clr = 4'b0001; @(negedge clk); flag_clr = 4'b0000; @(negedge clk);
        check(flags === 4'b1000, "R8", "clear other bit", 128'(flags), 128'(4'b1000));
        flag_clr = 4'b1000; @(negedge clk); flag_clr = 4'b0000; @(negedge clk);
        check(flags === 4'b0000, "R8", "clear sent bit", 128'(flags), 128'(4'b0000));
        check(busy === 1'b0, "R2", "no command launched by poke", 128'(busy), '0);

        check(sb_q.size() == 0 && frame_q.size() == 0 && card_q.size() == 0, "R1", "queues drained",
              128'(sb_q.size() + frame_q.size() + card_q.size()), '0);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule